// File: doc/BRIEF.md
# Parity-Protected Instruction Store Loader

This block is a host-loaded instruction memory for a small processing engine. Each location holds a 40-bit instruction together with two even-parity bits: one covering the low 20 instruction bits and one covering the high 20. The host loads the store through three write registers. The first is an address register, which also switches programming mode on and off. The second is a low data register that stages instruction bits 31:0. The third is a high data register that carries instruction bits 39:32 and the two parity bits. Writing the high register commits the staged entry and steps the address.

The engine reads the store through a separate fetch port. When parity checking is enabled, a fetched word whose stored parity disagrees with its content raises a one-cycle abort pulse and sets a parity-error flag that stays set until reset. The write address wraps to zero after the last location. The host can read the address register back at any time, so it can see the wrap, for example before padding the end of a program with no-operation words.

Top module: `istore_loader`

## Requirements
- R1: After reset, the address read-back is 0, and `fetch_valid`, `fetch_abort` and `par_err` are all 0.
- R2: A host write to offset 0x00 loads bit 31 as the programming-mode flag and bits AW-1:0 as the write address. The read-back returns the flag in bit 31 and the address in the low bits, so writing 0 ends programming and reads back as 0.
- R3: A write to offset 0x04 followed by a write to offset 0x08, both in programming mode, stores one entry. Instruction bits 31:0 come from the 0x04 data. Instruction bits 39:32 come from bits 7:0 of the 0x08 data. The parity bits come from bits 9:8 of the 0x08 data, with bit 8 for the low half and bit 9 for the high half.
- R4: Each write to offset 0x08 in programming mode advances the write address by one.
- R5: A commit at the last location wraps the write address to 0, so the read-back returns 0x80000000.
- R6: Writes to offset 0x04 or 0x08 outside programming mode change neither the stored contents nor the address register.
- R7: A fetch request is answered one clock later with `fetch_valid` high and `fetch_insn` equal to instruction bits 39:0 of the addressed entry.
- R8: When checking is enabled at request time, the stored low parity bit is compared with the XOR of instruction bits 19:0, and the stored high parity bit is compared with the XOR of bits 39:20. A mismatch in either half drives `fetch_abort` high in the `fetch_valid` cycle. That abort sets `par_err`, which stays high until reset.
- R9: When checking is disabled at request time, a fetch never raises `fetch_abort` or `par_err`, whatever the stored parity.
- R10: The pad word 0xF0000C0300, stored with both parity bits 0, fetches cleanly with checking enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_off | input | 8 | Register offset: 0x00 address, 0x04 low data, 0x08 high data |
| host_wdata | input | 32 | Host write data |
| host_addr_rb | output | 32 | Address register read-back: mode flag in bit 31, address in the low bits |
| par_chk_en | input | 1 | Parity-check enable, sampled together with the fetch request |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | AW | Fetch address |
| fetch_valid | output | 1 | Fetch result valid, one cycle after the request |
| fetch_insn | output | 40 | Fetched instruction |
| fetch_abort | output | 1 | Parity mismatch on the current fetch result |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The bench builds the block with AW=4, a 16-entry store. At that depth, one full loading pass in programming mode runs through every location and reaches the wrap to 0x80000000 within a few dozen cycles. The same small store can then be read back entry by entry, fetched back-to-back and corrupted in either parity half at chosen locations. The sticky error flag and the check-disabled case are then exercised against words with known bad parity.

// File: rtl/istore_pkg.sv
package istore_pkg;

    localparam logic [7:0] OFF_ADDR = 8'h00;
    localparam logic [7:0] OFF_LOW  = 8'h04;
    localparam logic [7:0] OFF_HIGH = 8'h08;

    localparam int INSN_W  = 40;
    localparam int ENTRY_W = INSN_W + 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ADDR,
        SEL_LOW,
        SEL_HIGH
    } host_sel_e;

    typedef struct packed {
        logic              par_hi;
        logic              par_lo;
        logic [INSN_W-1:0] insn;
    } entry_t;

    function automatic logic [1:0] calc_par(logic [INSN_W-1:0] w);
        return {^w[39:20], ^w[19:0]};
    endfunction

    function automatic host_sel_e decode_off(logic [7:0] off);
        case (off)
            OFF_ADDR: return SEL_ADDR;
            OFF_LOW:  return SEL_LOW;
            OFF_HIGH: return SEL_HIGH;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/istore_host_regs.sv
module istore_host_regs
    import istore_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_off,
    input  logic [31:0]   wr_data,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output entry_t        commit_entry,
    output logic [31:0]   addr_rb
);

    host_sel_e     sel;
    logic          prog_q;
    logic [AW-1:0] addr_q;
    logic [31:0]   low_q;
    logic          unused_wdata;

    assign sel          = decode_off(wr_off);
    assign unused_wdata = ^wr_data[30:AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= 1'b0;
            addr_q <= '0;
            low_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ADDR: begin
                    prog_q <= wr_data[31];
                    addr_q <= wr_data[AW-1:0];
                end
                SEL_LOW:  if (prog_q) low_q <= wr_data;
                SEL_HIGH: if (prog_q) addr_q <= addr_q + 1'b1;
                default:  ;
            endcase
        end
    end

    assign commit              = wr_en && (sel == SEL_HIGH) && prog_q;
    assign commit_addr         = addr_q;
    assign commit_entry.par_hi = wr_data[9];
    assign commit_entry.par_lo = wr_data[8];
    assign commit_entry.insn   = {wr_data[7:0], low_q};
    assign addr_rb             = {prog_q, 31'(addr_q)};

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_HIGH && prog_q) |=> addr_q == AW'($past(addr_q) + 1'b1)) // R4
        else $error("address did not advance on commit");

    AST_IGNORED_DATA: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_LOW || sel == SEL_HIGH) && !prog_q) |=> ($stable(addr_q) && !prog_q && $stable(low_q))) // R6
        else $error("data write outside programming changed state");

endmodule

// File: rtl/istore_array.sv
module istore_array
    import istore_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wentry,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output entry_t        rentry
);

    localparam int DEPTH = 1 << AW;

    entry_t mem [DEPTH];
    entry_t rd_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wentry;
        if (re) rd_q <= mem[raddr];
    end

    assign rentry = rd_q;

endmodule

// File: rtl/istore_fetch_chk.sv
module istore_fetch_chk
    import istore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              chk_en,
    input  entry_t            rentry,
    output logic              valid,
    output logic [INSN_W-1:0] insn,
    output logic              abort,
    output logic              perr
);

    logic v_q;
    logic en_q;
    logic perr_q;
    logic mismatch;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            en_q   <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            v_q    <= req;
            en_q   <= chk_en;
            perr_q <= perr_q | abort;
        end
    end

    assign mismatch = calc_par(rentry.insn) != {rentry.par_hi, rentry.par_lo};
    assign valid    = v_q;
    assign insn     = rentry.insn;
    assign abort    = v_q && en_q && mismatch;
    assign perr     = perr_q;

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        perr_q |=> perr_q) // R8
        else $error("parity flag dropped");

    AST_ABORT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        abort |=> perr_q) // R8
        else $error("abort did not set the parity flag");

endmodule

// File: rtl/istore_loader.sv
module istore_loader
    import istore_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [7:0]        host_off,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_addr_rb,
    input  logic              par_chk_en,
    input  logic              fetch_req,
    input  logic [AW-1:0]     fetch_addr,
    output logic              fetch_valid,
    output logic [INSN_W-1:0] fetch_insn,
    output logic              fetch_abort,
    output logic              par_err
);

    logic          commit;
    logic [AW-1:0] commit_addr;
    entry_t        commit_entry;
    entry_t        rd_entry;

    istore_host_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (host_we),
        .wr_off       (host_off),
        .wr_data      (host_wdata),
        .commit       (commit),
        .commit_addr  (commit_addr),
        .commit_entry (commit_entry),
        .addr_rb      (host_addr_rb)
    );

    istore_array #(.AW(AW)) u_array (
        .clk    (clk),
        .we     (commit),
        .waddr  (commit_addr),
        .wentry (commit_entry),
        .re     (fetch_req),
        .raddr  (fetch_addr),
        .rentry (rd_entry)
    );

    istore_fetch_chk u_chk (
        .clk    (clk),
        .rst    (rst),
        .req    (fetch_req),
        .chk_en (par_chk_en),
        .rentry (rd_entry),
        .valid  (fetch_valid),
        .insn   (fetch_insn),
        .abort  (fetch_abort),
        .perr   (par_err)
    );

    AST_FETCH_LATENCY: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> fetch_valid) // R7
        else $error("fetch not answered in one cycle");

    AST_NO_CHECK_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !par_chk_en) |=> !fetch_abort) // R9
        else $error("abort with checking disabled");

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |=> !fetch_valid) // R7
        else $error("valid without request");

endmodule

// File: tb/sim_istore_loader.sv
module sim_istore_loader;
    import istore_pkg::*;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [7:0]    host_off = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_addr_rb;
    logic          par_chk_en = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_valid;
    logic [39:0]   fetch_insn;
    logic          fetch_abort;
    logic          par_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [41:0] model [DEPTH];
    logic [40:0] exp_q [$];

    always #5 clk = ~clk;

    istore_loader #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_off(host_off),
        .host_wdata(host_wdata), .host_addr_rb(host_addr_rb),
        .par_chk_en(par_chk_en), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_insn(fetch_insn),
        .fetch_abort(fetch_abort), .par_err(par_err)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [7:0] off, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // writes one entry; flip selects parity halves to corrupt
    task automatic load_entry(logic [39:0] w, logic [1:0] flip, logic [AW-1:0] at);
        logic [1:0] p;
        p = {^w[39:20], ^w[19:0]} ^ flip;
        host_write(OFF_LOW, w[31:0]);
        host_write(OFF_HIGH, {22'd0, p, w[39:32]});
        model[at] = {p, w};
    endtask

    task automatic issue_fetch(logic [AW-1:0] a, logic en);
        logic [41:0] e;
        logic        ab;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; par_chk_en = en;
        e  = model[a];
        ab = en && (e[41:40] != {^e[39:20], ^e[19:0]});
        exp_q.push_back({ab, e[39:0]});
    endtask

    task automatic end_fetch();
        @(negedge clk);
        fetch_req = 1'b0; par_chk_en = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compares each result against the scoreboard (R7, R8)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && fetch_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected valid", 64'd1, 64'd0);
                end else begin
                    logic [40:0] x;
                    x = exp_q.pop_front();
                    check("R7 fetch word", 64'(fetch_insn), 64'(x[39:0]));
                    check("R8 abort", 64'(fetch_abort), 64'(x[40]));
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 readback", 64'(host_addr_rb), 64'd0);
        check("R1 valid", 64'(fetch_valid), 64'd0);
        check("R1 abort", 64'(fetch_abort), 64'd0);
        check("R1 perr", 64'(par_err), 64'd0);

        // R2 enter programming at 0, then R3/R4 fill, R5 wrap, R10 pad at end
        host_write(OFF_ADDR, 32'h8000_0000);
        check("R2 enter", 64'(host_addr_rb), 64'h8000_0000);
        for (int i = 0; i < DEPTH; i++) begin
            w = (i == DEPTH - 1) ? 40'hF0_000C_0300 : {8'(i * 37 + 5), 32'(i * 32'h1357_9BDF)};
            load_entry(w, 2'b00, AW'(i));
            if (i < DEPTH - 1)
                check("R4 step", 64'(host_addr_rb), 64'(32'h8000_0000 | 32'(i + 1)));
        end
        check("R5 wrap", 64'(host_addr_rb), 64'h8000_0000);

        host_write(OFF_ADDR, 32'h0);
        check("R2 end", 64'(host_addr_rb), 64'd0);
        host_write(OFF_ADDR, 32'h8000_0005);
        check("R2 at 5", 64'(host_addr_rb), 64'h8000_0005);
        host_write(OFF_ADDR, 32'h0);

        // R6 ignored data writes
        host_write(OFF_LOW, 32'hDEAD_BEEF);
        host_write(OFF_HIGH, 32'h0000_03AA);
        check("R6 addr unchanged", 64'(host_addr_rb), 64'd0);

        // R3/R7/R10 back-to-back read-back of the whole store with checking on
        for (int i = 0; i < DEPTH; i++) issue_fetch(AW'(i), 1'b1);
        end_fetch();
        check("R10 perr clean", 64'(par_err), 64'd0);

        // corrupt low half at 7 and high half at 8
        host_write(OFF_ADDR, 32'h8000_0007);
        load_entry(40'h12_3456_789A, 2'b01, 4'd7);
        load_entry(40'hA5_5A0F_F0C3, 2'b10, 4'd8);
        host_write(OFF_ADDR, 32'h0);

        // R9 checking disabled
        issue_fetch(4'd7, 1'b0);
        issue_fetch(4'd8, 1'b0);
        end_fetch();
        check("R9 perr stays 0", 64'(par_err), 64'd0);

        // R8 low-half mismatch
        issue_fetch(4'd7, 1'b1);
        end_fetch();
        check("R8 perr set", 64'(par_err), 64'd1);
        // R8 sticky across a clean fetch, high-half mismatch
        issue_fetch(4'd3, 1'b1);
        issue_fetch(4'd8, 1'b1);
        end_fetch();
        check("R8 perr sticky", 64'(par_err), 64'd1);

        repeat (2) @(negedge clk);
        check("R7 all answered", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule